// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the general-purpose and status register storage of a small 32-bit core that runs in one of seven operating modes. A 4-bit register index and a 5-bit mode code together choose a physical register. Some indices resolve to storage shared by several modes, and others resolve to storage that belongs to one mode only. That lets a handler change its stack pointer, its link register or (in fast-interrupt mode) its upper working registers without disturbing the interrupted code.

The physical store holds 31 general registers and 6 status registers. The status registers are one current status word plus one saved status word for each of the five exception modes. Two combinational read ports and one write port work against the mode given on `mode_i`. A second write port serves exception entry: in the same cycle it writes the link register and the saved status of an explicitly named target mode.

Every port is a plain per-cycle strobe. The file accepts a write on every clock and has no back-pressure, so there is no valid/ready pair at its edge.

Top module: `mode_bank_regfile`

## Requirements
- R1: After reset, every general register, the current status word and all five saved status words read as zero.
- R2: Mode codes are 10000 user, 10001 fast interrupt, 10010 interrupt, 10011 supervisor, 10111 abort, 11011 undefined and 11111 system. Any other code is banked as user mode. System mode and user mode see the same registers at indices 0 to 14.
- R3: In fast-interrupt mode, indices 8 to 14 select seven registers that no other mode can reach. Indices 0 to 7 are shared with user mode.
- R4: In interrupt, supervisor, abort and undefined modes, indices 13 and 14 select a pair of registers private to that mode. Indices 0 to 12 are shared with user mode.
- R5: Index 15 is one program counter register common to all modes, and its value is always driven on `pc_o`.
- R6: A read of a register that is written in the same cycle returns the old value. The new value appears from the next cycle on.
- R7: `spsr_o` shows the saved status word of the current mode, and `spsr_we` writes that word. In user, system or unlisted modes, `spsr_o` reads zero and `spsr_we` has no effect.
- R8: When `exc_en` is high, the target mode's index-14 register takes `exc_link` and its saved status word takes `exc_spsr`, whatever `mode_i` is. If the target is user or system, only the link write happens.
- R9: When `cpsr_we` is high, `cpsr_o` shows `cpsr_wdata` from the next cycle on.
- R10: When the normal write port and the exception port hit the same physical register or saved status word in the same cycle, the exception port's value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 5 | Current operating mode code |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Normal write strobe |
| wr_idx | input | 4 | Normal write register index |
| wr_data | input | 32 | Normal write data |
| exc_en | input | 1 | Exception entry write strobe |
| exc_mode | input | 5 | Target mode of the exception entry |
| exc_link | input | 32 | Return address for the target link register |
| exc_spsr | input | 32 | Status word saved for the target mode |
| cpsr_we | input | 1 | Current status write strobe |
| cpsr_wdata | input | 32 | Current status write data |
| cpsr_o | output | 32 | Current status word |
| spsr_we | input | 1 | Saved status write strobe for the current mode |
| spsr_wdata | input | 32 | Saved status write data |
| spsr_o | output | 32 | Saved status word of the current mode |
| pc_o | output | 32 | Program counter |

## Verification
Directed writes in one mode are followed by reads of the same index in a mode that shares the register and in a mode that banks it. This tells a correct alias apart from a wrongly shared or wrongly private register at the R8, R12/R13 and R14 boundaries. Reads of the very register being written expose any write-to-read bypass. Exception entry is driven while `mode_i` names a different mode, and again colliding with a normal write, to show the target is taken from `exc_mode` and that the exception value wins. A long random run then mixes all seven codes plus unlisted codes, all indices and all strobes, and compares both read ports, the program counter and both status outputs against a bench model keyed by owning mode.

// File: rtl/mbrf_pkg.sv
package mbrf_pkg;

  localparam int DATA_W    = 32;
  localparam int IDX_W     = 4;
  localparam int MODE_W    = 5;
  localparam int NUM_GPR   = 31;
  localparam int PHYS_W    = $clog2(NUM_GPR);
  localparam int NUM_SAVED = 5;

  typedef enum logic [2:0] {
    BK_USR = 3'd0,
    BK_FIQ = 3'd1,
    BK_IRQ = 3'd2,
    BK_SVC = 3'd3,
    BK_ABT = 3'd4,
    BK_UND = 3'd5
  } bank_e;

  localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
  localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
  localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;

  // System and unlisted codes fall back to the user bank
  function automatic bank_e bank_of(input logic [MODE_W-1:0] m);
    case (m)
      MODE_FIQ: return BK_FIQ;
      MODE_IRQ: return BK_IRQ;
      MODE_SVC: return BK_SVC;
      MODE_ABT: return BK_ABT;
      MODE_UND: return BK_UND;
      default:  return BK_USR;
    endcase
  endfunction

endpackage

// File: rtl/rf_bank_map.sv
module rf_bank_map
  import mbrf_pkg::*;
#(
  parameter int IW = IDX_W,
  parameter int PW = PHYS_W
) (
  input  logic [MODE_W-1:0] mode,
  input  logic [IW-1:0]     idx,
  output logic [PW-1:0]     phys
);
  localparam int PC_IDX    = (1 << IW) - 1;
  localparam int FIQ_LO    = 8;
  localparam int PAIR_LO   = PC_IDX - 2;
  localparam int FIQ_BASE  = PC_IDX;
  localparam int PAIR_BASE = FIQ_BASE + (PC_IDX - FIQ_LO);
  localparam int PC_PHYS   = PAIR_BASE + 2 * 4;

  bank_e bk;
  int    ix;
  int    slot;

  always_comb begin
    bk   = bank_of(mode);
    ix   = int'(idx);
    slot = ix;
    if (ix == PC_IDX) begin
      slot = PC_PHYS;
    end else if (bk == BK_FIQ && ix >= FIQ_LO) begin
      slot = FIQ_BASE + (ix - FIQ_LO);
    end else if (bk != BK_USR && bk != BK_FIQ && ix >= PAIR_LO) begin
      slot = PAIR_BASE + 2 * (int'(bk) - int'(BK_IRQ)) + (ix - PAIR_LO);
    end
    phys = PW'(slot);
  end
endmodule

// File: rtl/rf_gpr_array.sv
module rf_gpr_array #(
  parameter int DW  = 32,
  parameter int NUM = 31,
  parameter int AW  = $clog2(NUM)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_n,
  input  logic [AW-1:0] wa_n,
  input  logic [DW-1:0] wd_n,
  input  logic          we_x,
  input  logic [AW-1:0] wa_x,
  input  logic [DW-1:0] wd_x,
  input  logic [AW-1:0] ra0,
  output logic [DW-1:0] rd0,
  input  logic [AW-1:0] ra1,
  output logic [DW-1:0] rd1,
  output logic [DW-1:0] top_q
);
  logic [DW-1:0] q [NUM];

  for (genvar g = 0; g < NUM; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                q[g] <= '0;
      else if (we_x && wa_x == AW'(g))           q[g] <= wd_x;
      else if (we_n && wa_n == AW'(g))           q[g] <= wd_n;
    end
  end

  always_comb begin
    rd0 = (int'(ra0) < NUM) ? q[ra0] : '0;
    rd1 = (int'(ra1) < NUM) ? q[ra1] : '0;
  end

  assign top_q = q[NUM-1];
endmodule

// File: rtl/rf_saved_bank.sv
module rf_saved_bank
  import mbrf_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] cur_mode,
  input  logic              cur_we,
  input  logic [DW-1:0]     cur_wd,
  input  logic              exc_we,
  input  logic [MODE_W-1:0] exc_mode,
  input  logic [DW-1:0]     exc_wd,
  output logic [DW-1:0]     rd_o
);
  logic [DW-1:0] sv [NUM_SAVED];
  bank_e cur_bk, exc_bk;

  assign cur_bk = bank_of(cur_mode);
  assign exc_bk = bank_of(exc_mode);

  for (genvar s = 0; s < NUM_SAVED; s++) begin : g_sv
    localparam bank_e OWN = bank_e'(s + 1);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          sv[s] <= '0;
      else if (exc_we && exc_bk == OWN)    sv[s] <= exc_wd;
      else if (cur_we && cur_bk == OWN)    sv[s] <= cur_wd;
    end
  end

  always_comb begin
    if (cur_bk == BK_USR) rd_o = '0;
    else                  rd_o = sv[int'(cur_bk) - 1];
  end
endmodule

// File: rtl/mode_bank_regfile.sv
module mode_bank_regfile
  import mbrf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              exc_en,
  input  logic [MODE_W-1:0] exc_mode,
  input  logic [DATA_W-1:0] exc_link,
  input  logic [DATA_W-1:0] exc_spsr,
  input  logic              cpsr_we,
  input  logic [DATA_W-1:0] cpsr_wdata,
  output logic [DATA_W-1:0] cpsr_o,
  input  logic              spsr_we,
  input  logic [DATA_W-1:0] spsr_wdata,
  output logic [DATA_W-1:0] spsr_o,
  output logic [DATA_W-1:0] pc_o
);
  localparam logic [IDX_W-1:0] LINK_IDX = IDX_W'((1 << IDX_W) - 2);

  logic [PHYS_W-1:0] pa_a, pa_b, pa_w, pa_x;
  logic [DATA_W-1:0] cpsr_q;

  rf_bank_map u_map_a (.mode(mode_i),   .idx(rd_a_idx), .phys(pa_a));
  rf_bank_map u_map_b (.mode(mode_i),   .idx(rd_b_idx), .phys(pa_b));
  rf_bank_map u_map_w (.mode(mode_i),   .idx(wr_idx),   .phys(pa_w));
  rf_bank_map u_map_x (.mode(exc_mode), .idx(LINK_IDX), .phys(pa_x));

  rf_gpr_array #(.DW(DATA_W), .NUM(NUM_GPR), .AW(PHYS_W)) u_gpr (
    .clk   (clk),
    .rst_n (rst_n),
    .we_n  (wr_en),
    .wa_n  (pa_w),
    .wd_n  (wr_data),
    .we_x  (exc_en),
    .wa_x  (pa_x),
    .wd_x  (exc_link),
    .ra0   (pa_a),
    .rd0   (rd_a_data),
    .ra1   (pa_b),
    .rd1   (rd_b_data),
    .top_q (pc_o)
  );

  rf_saved_bank #(.DW(DATA_W)) u_saved (
    .clk      (clk),
    .rst_n    (rst_n),
    .cur_mode (mode_i),
    .cur_we   (spsr_we),
    .cur_wd   (spsr_wdata),
    .exc_we   (exc_en),
    .exc_mode (exc_mode),
    .exc_wd   (exc_spsr),
    .rd_o     (spsr_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cpsr_q <= '0;
    else if (cpsr_we) cpsr_q <= cpsr_wdata;
  end

  assign cpsr_o = cpsr_q;
endmodule

// File: rtl/mbrf_chk.sv
module mbrf_chk
  import mbrf_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [MODE_W-1:0] mode_i,
  input logic [IDX_W-1:0]  rd_a_idx,
  input logic [DATA_W-1:0] rd_a_data,
  input logic [IDX_W-1:0]  rd_b_idx,
  input logic [DATA_W-1:0] rd_b_data,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic              exc_en,
  input logic [MODE_W-1:0] exc_mode,
  input logic [DATA_W-1:0] exc_link,
  input logic [DATA_W-1:0] exc_spsr,
  input logic              cpsr_we,
  input logic [DATA_W-1:0] cpsr_wdata,
  input logic [DATA_W-1:0] cpsr_o,
  input logic              spsr_we,
  input logic [DATA_W-1:0] spsr_wdata,
  input logic [DATA_W-1:0] spsr_o,
  input logic [DATA_W-1:0] pc_o
);
  localparam logic [IDX_W-1:0] PCI = IDX_W'((1 << IDX_W) - 1);

  // R5
  pc_port_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == PCI) |-> (rd_a_data == pc_o));

  // R5
  pc_port_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_b_idx == PCI) |-> (rd_b_data == pc_o));

  // R6
  pc_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == PCI) |=> (pc_o == $past(wr_data)));

  // R9
  status_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpsr_we |=> (cpsr_o == $past(cpsr_wdata)));

  // R7
  no_saved_in_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_of(mode_i) == BK_USR) |-> (spsr_o == '0));

  // R8
  exc_saves_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_en && bank_of(exc_mode) != BK_USR && exc_mode == mode_i)
      |=> (mode_i != $past(mode_i)) || (spsr_o == $past(exc_spsr)));
endmodule

bind mode_bank_regfile mbrf_chk u_chk (.*);

// File: tb/mode_bank_regfile_tb.sv
`timescale 1ns/1ps
module mode_bank_regfile_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  mode_i = 5'b10000;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
  logic        wr_en = 1'b0, exc_en = 1'b0, cpsr_we = 1'b0, spsr_we = 1'b0;
  logic [4:0]  exc_mode = 5'b10000;
  logic [31:0] exc_link = '0, exc_spsr = '0, cpsr_wdata = '0, spsr_wdata = '0;
  logic [31:0] cpsr_o, spsr_o, pc_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  mode_bank_regfile u_dut (.*);

  // Model: one 16-entry view per owning bank (0 user, 1 fiq, 2 irq, 3 svc, 4 abt, 5 und)
  logic [31:0] m  [6][16];
  logic [31:0] sv [6];
  logic [31:0] cp;

  function automatic int ref_bank(input logic [4:0] c);
    case (c)
      5'b10001: return 1;
      5'b10010: return 2;
      5'b10011: return 3;
      5'b10111: return 4;
      5'b11011: return 5;
      default:  return 0;
    endcase
  endfunction

  function automatic int owner(input int b, input int i);
    if (i == 15) return 0;
    if (b == 1 && i >= 8) return 1;
    if (b >= 2 && i >= 13) return b;
    return 0;
  endfunction

  function automatic logic [31:0] ref_rd(input logic [4:0] c, input logic [3:0] i);
    return m[owner(ref_bank(c), int'(i))][i];
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; exc_en = 0; cpsr_we = 0; spsr_we = 0;
  endtask

  // Called just after a falling edge with inputs set; checks, then takes one edge
  task automatic step(input string tag);
    int b, xb;
    #1;
    chk({tag, " port A"}, rd_a_data, ref_rd(mode_i, rd_a_idx));
    chk({tag, " port B"}, rd_b_data, ref_rd(mode_i, rd_b_idx));
    chk({tag, " R5 pc"}, pc_o, m[0][15]);
    chk({tag, " R9 cpsr"}, cpsr_o, cp);
    b = ref_bank(mode_i);
    chk({tag, " R7 spsr"}, spsr_o, (b == 0) ? 32'h0 : sv[b]);
    @(posedge clk);
    xb = ref_bank(exc_mode);
    if (wr_en) m[owner(b, int'(wr_idx))][wr_idx] = wr_data;
    if (exc_en) m[owner(xb, 14)][14] = exc_link;
    if (spsr_we && b != 0) sv[b] = spsr_wdata;
    if (exc_en && xb != 0) sv[xb] = exc_spsr;
    if (cpsr_we) cp = cpsr_wdata;
    @(negedge clk);
  endtask

  task automatic rd(input logic [4:0] c, input logic [3:0] a, input logic [3:0] bb, input string tag);
    idle(); mode_i = c; rd_a_idx = a; rd_b_idx = bb;
    step(tag);
  endtask

  task automatic wr(input logic [4:0] c, input logic [3:0] i, input logic [31:0] d, input string tag);
    idle(); mode_i = c; wr_en = 1; wr_idx = i; wr_data = d; rd_a_idx = i; rd_b_idx = i;
    step(tag);
  endtask

  logic [4:0] codes [7] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011, 5'b10111, 5'b11011, 5'b11111};

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unused;
    unused = $urandom(32'h5eed_1234);
    for (int b = 0; b < 6; b++) begin
      sv[b] = '0;
      for (int i = 0; i < 16; i++) m[b][i] = '0;
    end
    cp = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state in several modes
    rd(5'b10000, 4'd0, 4'd14, "R1 user");
    rd(5'b10001, 4'd9, 4'd14, "R1 fiq");
    rd(5'b11011, 4'd13, 4'd15, "R1 und");

    // R3 / R4 / R2 aliasing around index 8
    wr(5'b10000, 4'd8, 32'hA000_0008, "R6 user r8 write");
    rd(5'b10001, 4'd8, 4'd7, "R3 fiq r8 private");
    rd(5'b10010, 4'd8, 4'd12, "R4 irq r8 shared");
    rd(5'b11111, 4'd8, 4'd8, "R2 sys r8 shared");
    rd(5'b00101, 4'd8, 4'd8, "R2 unlisted code as user");
    wr(5'b10001, 4'd14, 32'hF1F1_0014, "R3 fiq r14 write");
    rd(5'b10000, 4'd14, 4'd8, "R3 user r14 untouched");
    rd(5'b10001, 4'd14, 4'd8, "R3 fiq r14 readback");

    // R4: stack pointer pairs
    wr(5'b10011, 4'd13, 32'h5C5C_0013, "R4 svc sp write");
    wr(5'b10111, 4'd13, 32'hAB0A_0013, "R4 abt sp write");
    rd(5'b10011, 4'd13, 4'd12, "R4 svc sp");
    rd(5'b10111, 4'd13, 4'd14, "R4 abt sp");
    rd(5'b10000, 4'd13, 4'd13, "R4 user sp");
    wr(5'b10010, 4'd12, 32'h1200_000C, "R4 irq r12 write");
    rd(5'b10000, 4'd12, 4'd12, "R4 user sees r12");

    // R5: program counter common
    wr(5'b11011, 4'd15, 32'h0000_0400, "R5 pc write");
    rd(5'b10001, 4'd15, 4'd15, "R5 pc from fiq");

    // R6: same-cycle read sees old value, next cycle new
    wr(5'b10000, 4'd8, 32'hBEEF_0008, "R6 same-cycle old");
    rd(5'b10000, 4'd8, 4'd8, "R6 next-cycle new");

    // R7: saved status per mode; ignored in user/system
    idle(); mode_i = 5'b10011; spsr_we = 1; spsr_wdata = 32'h0000_01D3; step("R7 svc spsr write");
    idle(); mode_i = 5'b10000; spsr_we = 1; spsr_wdata = 32'hDEAD_0000; step("R7 user spsr ignored");
    idle(); mode_i = 5'b11111; spsr_we = 1; spsr_wdata = 32'hDEAD_0001; step("R7 sys spsr ignored");
    rd(5'b10011, 4'd0, 4'd1, "R7 svc spsr kept");
    rd(5'b10010, 4'd0, 4'd1, "R7 irq spsr separate");

    // R8: exception entry targets exc_mode regardless of mode_i
    idle(); mode_i = 5'b10000; exc_en = 1; exc_mode = 5'b10010;
    exc_link = 32'h0000_8004; exc_spsr = 32'h0000_0010; step("R8 exc into irq");
    rd(5'b10000, 4'd14, 4'd13, "R8 user r14 untouched");
    rd(5'b10010, 4'd14, 4'd13, "R8 irq link and spsr");
    idle(); mode_i = 5'b10011; exc_en = 1; exc_mode = 5'b11111;
    exc_link = 32'h0000_9008; exc_spsr = 32'hCAFE_0000; step("R8 exc into sys link only");
    rd(5'b10000, 4'd14, 4'd14, "R8 sys link lands in user r14");

    // R10: collision, exception port wins
    idle(); mode_i = 5'b10011; wr_en = 1; wr_idx = 4'd14; wr_data = 32'h1111_1111;
    spsr_we = 1; spsr_wdata = 32'h2222_2222;
    exc_en = 1; exc_mode = 5'b10011; exc_link = 32'h3333_3333; exc_spsr = 32'h4444_4444;
    step("R10 collision");
    rd(5'b10011, 4'd14, 4'd13, "R10 exc value kept");

    // R9
    idle(); cpsr_we = 1; cpsr_wdata = 32'h6000_00D3; step("R9 cpsr write");
    rd(5'b10000, 4'd0, 4'd0, "R9 cpsr readback");

    // Random mix: R2 R3 R4 R6 R7 R8 R10
    for (int n = 0; n < 3000; n++) begin
      idle();
      mode_i     = ($urandom % 9 == 0) ? 5'($urandom) : codes[$urandom % 7];
      rd_a_idx   = 4'($urandom);
      rd_b_idx   = 4'($urandom);
      wr_en      = ($urandom % 2) == 0;
      wr_idx     = 4'($urandom);
      wr_data    = $urandom;
      exc_en     = ($urandom % 6) == 0;
      exc_mode   = codes[$urandom % 7];
      exc_link   = $urandom;
      exc_spsr   = $urandom;
      spsr_we    = ($urandom % 4) == 0;
      spsr_wdata = $urandom;
      cpsr_we    = ($urandom % 5) == 0;
      cpsr_wdata = $urandom;
      step("R2 R3 R4 R6 R8 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule